// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block is the pixel-clock timing engine of a video display interface. A small write-only register port sets up the horizontal line length and sync pulse, the vertical frame length and sync pulse, the displayed region, an active picture region nested inside it, a separate data-valid column range for compressed or double-width data, and the polarity of each strobe. Once enabled, the block produces hsync, vsync, display-enable and data-valid strobes. It also reports live line and frame counts.

Vertical positions are not line numbers. They are absolute pixel-clock offsets from the start of the frame. Software folds the line length and any hsync skew into them, for example a display start of (sync lines + back porch lines) × line length + skew. Inside the active region the block passes the upstream pixel through. If upstream has no pixel ready, it substitutes an underflow colour. Everywhere else it outputs a border colour.

Top module: `disp_timing_gen`

## Requirements
- R1: Register 1 holds the line length in pixel clocks in bits 31:16 and the hsync width in bits 15:0. The column counter runs from 0 to length−1, and the raw hsync is asserted while the column is below the width.
- R2: Register 2 holds the frame length and register 3 the vsync width, both in pixel clocks. A frame position counter runs from 0 to frame length−1, and the raw vsync is asserted while the position is below the vsync width.
- R3: The raw display-enable is asserted when two conditions hold together. The column must lie in the inclusive range given by register 6 (end in bits 31:16, start in bits 15:0). The frame position must lie in the inclusive range from register 4 (start) to register 5 (end).
- R4: The active region is the display region further limited by two windows. When register 11 bit 0 is set, the column must lie in the range of register 9 (end 31:16, start 15:0). When register 11 bit 1 is set, the position must lie from register 7 to register 8. In the active region pix_ready_o is high, and pixel_o carries pix_i when pix_valid_i is high and the underflow colour (register 14) otherwise.
- R5: While the engine is enabled, pixel_o carries the border colour (register 13) outside the active region.
- R6: data_valid_o is high when register 11 bit 2 is set, the column lies in the range of register 10 (end 31:16, start 15:0), and the position lies in the display vertical range.
- R7: Register 12 inverts the output levels: bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts display-enable.
- R8: The line count increments each time the column counter wraps and returns to 0 when the frame counter wraps. The frame count increments at each frame wrap. Both counts are 16 bits wide.
- R9: A write to register 15 with bit 31 set returns both counters and both positions to 0 on the next cycle. This takes precedence over a wrap that falls in the same cycle.
- R10: Register 0 bit 0 enables the engine, and positions start from 0 in the cycle after it is set. While the engine is disabled, both counts read 0, hsync, vsync and display-enable sit at their inactive levels, and data_valid_o, pix_ready_o and pixel_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| pix_i | input | 24 | Upstream pixel |
| pix_valid_i | input | 1 | Upstream pixel is available |
| pix_ready_o | output | 1 | Pixel is consumed this cycle (active region) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| data_valid_o | output | 1 | Data-valid window strobe |
| pixel_o | output | 24 | Output pixel |
| line_cnt_o | output | 16 | Line count within frame |
| frame_cnt_o | output | 16 | Frame count |

## Verification
The counter clear and the frame wrap can fall in the same cycle. That cycle moves the frame count one way or the other. The bench provokes the collision by issuing the clear write in the last pixel clock of a frame, so that the clear and the wrap hit the same edge. It judges the result from the counts and strobes that follow: position and frame count must both restart at 0, and the frame count must not show the step to 1.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int HW = 16;   // column width
  localparam int VW = 32;   // frame position width
  localparam int CW = 24;   // colour width
  localparam int AW = 4;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_ENABLE  = 4'd0;
  localparam logic [AW-1:0] A_HCTL    = 4'd1;
  localparam logic [AW-1:0] A_VLEN    = 4'd2;
  localparam logic [AW-1:0] A_VPULSE  = 4'd3;
  localparam logic [AW-1:0] A_DV_LO   = 4'd4;
  localparam logic [AW-1:0] A_DV_HI   = 4'd5;
  localparam logic [AW-1:0] A_DH_WIN  = 4'd6;
  localparam logic [AW-1:0] A_AV_LO   = 4'd7;
  localparam logic [AW-1:0] A_AV_HI   = 4'd8;
  localparam logic [AW-1:0] A_AH_WIN  = 4'd9;
  localparam logic [AW-1:0] A_XH_WIN  = 4'd10;
  localparam logic [AW-1:0] A_MODE    = 4'd11;
  localparam logic [AW-1:0] A_POL     = 4'd12;
  localparam logic [AW-1:0] A_BORDER  = 4'd13;
  localparam logic [AW-1:0] A_UFLOW   = 4'd14;
  localparam logic [AW-1:0] A_CNT_CTL = 4'd15;

  typedef struct packed {
    logic [HW-1:0] h_len;
    logic [HW-1:0] h_pw;
    logic [VW-1:0] v_len;
    logic [VW-1:0] v_pw;
    logic [VW-1:0] dv_lo;
    logic [VW-1:0] dv_hi;
    logic [VW-1:0] av_lo;
    logic [VW-1:0] av_hi;
    logic [HW-1:0] dh_lo;
    logic [HW-1:0] dh_hi;
    logic [HW-1:0] ah_lo;
    logic [HW-1:0] ah_hi;
    logic [HW-1:0] xh_lo;
    logic [HW-1:0] xh_hi;
    logic          ah_en;
    logic          av_en;
    logic          xh_en;
    logic [2:0]    pol;
    logic [CW-1:0] border;
    logic [CW-1:0] uflow;
  } dtg_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output dtg_cfg_t      cfg_o,
  output logic          en_o,
  output logic          clr_o
);
  dtg_cfg_t cfg_q;
  logic     en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_ENABLE: en_q <= wdata_i[0];
        A_HCTL:   {cfg_q.h_len, cfg_q.h_pw} <= wdata_i;
        A_VLEN:   cfg_q.v_len <= wdata_i;
        A_VPULSE: cfg_q.v_pw  <= wdata_i;
        A_DV_LO:  cfg_q.dv_lo <= wdata_i;
        A_DV_HI:  cfg_q.dv_hi <= wdata_i;
        A_DH_WIN: {cfg_q.dh_hi, cfg_q.dh_lo} <= wdata_i;
        A_AV_LO:  cfg_q.av_lo <= wdata_i;
        A_AV_HI:  cfg_q.av_hi <= wdata_i;
        A_AH_WIN: {cfg_q.ah_hi, cfg_q.ah_lo} <= wdata_i;
        A_XH_WIN: {cfg_q.xh_hi, cfg_q.xh_lo} <= wdata_i;
        A_MODE:   {cfg_q.xh_en, cfg_q.av_en, cfg_q.ah_en} <= wdata_i[2:0];
        A_POL:    cfg_q.pol <= wdata_i[2:0];
        A_BORDER: cfg_q.border <= wdata_i[CW-1:0];
        A_UFLOW:  cfg_q.uflow  <= wdata_i[CW-1:0];
        default:  ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;
  assign clr_o = we_i && (addr_i == A_CNT_CTL) && wdata_i[DW-1];
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [HW-1:0]      h_len_i,
  input  logic [VW-1:0]      v_len_i,
  output logic [HW-1:0]      col_o,
  output logic [VW-1:0]      pos_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic h_wrap, v_wrap;

  // >= keeps the counters bounded if a length shrinks mid-line
  assign h_wrap = col_o >= (h_len_i - HW'(1));
  assign v_wrap = pos_o >= (v_len_i - VW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o   <= '0;
      pos_o   <= '0;
      line_o  <= '0;
      frame_o <= '0;
    end else if (!en_i || clr_i) begin
      col_o   <= '0;
      pos_o   <= '0;
      line_o  <= '0;
      frame_o <= '0;
    end else begin
      col_o <= h_wrap ? '0 : col_o + HW'(1);
      if (v_wrap) begin
        pos_o   <= '0;
        line_o  <= '0;
        frame_o <= frame_o + FRAME_W'(1);
      end else begin
        pos_o <= pos_o + VW'(1);
        if (h_wrap) line_o <= line_o + LINE_W'(1);
      end
    end
  end
endmodule

// File: rtl/dtg_span.sv
module dtg_span #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_o
);
  assign in_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  input  logic [CW-1:0]      pix_i,
  input  logic               pix_valid_i,
  output logic               pix_ready_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               data_valid_o,
  output logic [CW-1:0]      pixel_o,
  output logic [LINE_W-1:0]  line_cnt_o,
  output logic [FRAME_W-1:0] frame_cnt_o
);
  localparam int NH = 3;  // display, active, data columns
  localparam int NV = 2;  // display, active positions

  dtg_cfg_t           cfg;
  logic               eng_en, cnt_clr;
  logic [HW-1:0]      col;
  logic [VW-1:0]      pos;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;

  dtg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .en_o(eng_en), .clr_o(cnt_clr)
  );

  dtg_counters #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(eng_en), .clr_i(cnt_clr),
    .h_len_i(cfg.h_len), .v_len_i(cfg.v_len),
    .col_o(col), .pos_o(pos), .line_o(line_q), .frame_o(frame_q)
  );

  logic [HW-1:0] h_lo [NH];
  logic [HW-1:0] h_hi [NH];
  logic [VW-1:0] v_lo [NV];
  logic [VW-1:0] v_hi [NV];
  logic [NH-1:0] in_h;
  logic [NV-1:0] in_v;

  assign h_lo[0] = cfg.dh_lo;  assign h_hi[0] = cfg.dh_hi;
  assign h_lo[1] = cfg.ah_lo;  assign h_hi[1] = cfg.ah_hi;
  assign h_lo[2] = cfg.xh_lo;  assign h_hi[2] = cfg.xh_hi;
  assign v_lo[0] = cfg.dv_lo;  assign v_hi[0] = cfg.dv_hi;
  assign v_lo[1] = cfg.av_lo;  assign v_hi[1] = cfg.av_hi;

  for (genvar i = 0; i < NH; i++) begin : g_hspan
    dtg_span #(.W(HW)) u_span (.val_i(col), .lo_i(h_lo[i]), .hi_i(h_hi[i]), .in_o(in_h[i]));
  end
  for (genvar i = 0; i < NV; i++) begin : g_vspan
    dtg_span #(.W(VW)) u_span (.val_i(pos), .lo_i(v_lo[i]), .hi_i(v_hi[i]), .in_o(in_v[i]));
  end

  logic       disp, act;
  logic [2:0] strobe_raw, strobe_out;

  assign disp = in_h[0] && in_v[0];
  assign act  = disp && (!cfg.ah_en || in_h[1]) && (!cfg.av_en || in_v[1]);

  assign strobe_raw = {disp, pos < cfg.v_pw, col < cfg.h_pw} & {3{eng_en}};

  for (genvar i = 0; i < 3; i++) begin : g_pol
    assign strobe_out[i] = strobe_raw[i] ^ cfg.pol[i];
  end

  assign hsync_o      = strobe_out[0];
  assign vsync_o      = strobe_out[1];
  assign de_o         = strobe_out[2];
  assign data_valid_o = eng_en && cfg.xh_en && in_h[2] && in_v[0];
  assign pix_ready_o  = eng_en && act;

  always_comb begin
    if (!eng_en)          pixel_o = '0;
    else if (!act)        pixel_o = cfg.border;
    else if (pix_valid_i) pixel_o = pix_i;
    else                  pixel_o = cfg.uflow;
  end

  assign line_cnt_o  = eng_en ? line_q  : '0;
  assign frame_cnt_o = eng_en ? frame_q : '0;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int FRAME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               cfg_we_i,
  input logic [AW-1:0]      cfg_addr_i,
  input logic [DW-1:0]      cfg_wdata_i,
  input logic [CW-1:0]      pix_i,
  input logic               pix_valid_i,
  input logic               pix_ready_o,
  input logic               data_valid_o,
  input logic [CW-1:0]      pixel_o,
  input logic [FRAME_W-1:0] frame_cnt_o,
  input logic [LINE_W-1:0]  cnt_line_i,
  input logic [FRAME_W-1:0] cnt_frame_i
);
  p_frame_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_o != $past(frame_cnt_o)) |->
      (frame_cnt_o == $past(frame_cnt_o) + FRAME_W'(1)) || (frame_cnt_o == '0));

  p_pass_pixel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && pix_valid_i) |-> (pixel_o == pix_i));

  p_clear_counts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == A_CNT_CTL && cfg_wdata_i[DW-1]) |=>
      (cnt_line_i == '0 && cnt_frame_i == '0));

  p_off_counters_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_line_i == '0 && cnt_frame_i == '0));

  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!pix_ready_o && !data_valid_o && pixel_o == '0));
endmodule

bind disp_timing_gen dtg_checker #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(eng_en),
  .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
  .pix_i(pix_i), .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o),
  .data_valid_o(data_valid_o), .pixel_o(pixel_o), .frame_cnt_o(frame_cnt_o),
  .cnt_line_i(line_q), .cnt_frame_i(frame_q)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;
  localparam int HP = 10, HPW = 2, VP = 60, VPW = 10;
  localparam int DH_LO = 4, DH_HI = 8, AH_LO = 5, AH_HI = 7, XH_LO = 4, XH_HI = 5;
  localparam logic [23:0] BORDER = 24'h0000AA, UFLOW = 24'hFF0000;

  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [3:0]  cfg_addr_i = 0;
  logic [31:0] cfg_wdata_i = 0;
  logic [23:0] pix_i = 0;
  logic        pix_valid_i = 0;
  logic        pix_ready_o, hsync_o, vsync_o, de_o, data_valid_o;
  logic [23:0] pixel_o;
  logic [15:0] line_cnt_o, frame_cnt_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  disp_timing_gen dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i);
    #2 cfg_we_i = 0;
  endtask

  task automatic chk_off(logic [2:0] pol, string tag);
    chk(tag, "hsync", hsync_o, pol[0]);
    chk(tag, "vsync", vsync_o, pol[1]);
    chk(tag, "de", de_o, pol[2]);
    chk(tag, "data_valid", data_valid_o, 0);
    chk(tag, "ready", pix_ready_o, 0);
    chk(tag, "pixel", pixel_o, 0);
    chk(tag, "line", line_cnt_o, 0);
    chk(tag, "frame", frame_cnt_o, 0);
  endtask

  // one configured run: mode bits, polarity, vertical skew, clear cycle (-1 none)
  task automatic run(logic [2:0] mode, logic [2:0] pol, int skew, int clr_at, int ncyc);
    int dvs = 20 + skew, dve = 49 + skew, avs = 30 + skew, ave = 39 + skew;
    int k = 0;
    wr(dtg_pkg::A_HCTL, (HP << 16) | HPW);
    wr(dtg_pkg::A_VLEN, VP);
    wr(dtg_pkg::A_VPULSE, VPW);
    wr(dtg_pkg::A_DV_LO, dvs);
    wr(dtg_pkg::A_DV_HI, dve);
    wr(dtg_pkg::A_DH_WIN, (DH_HI << 16) | DH_LO);
    wr(dtg_pkg::A_AV_LO, avs);
    wr(dtg_pkg::A_AV_HI, ave);
    wr(dtg_pkg::A_AH_WIN, (AH_HI << 16) | AH_LO);
    wr(dtg_pkg::A_XH_WIN, (XH_HI << 16) | XH_LO);
    wr(dtg_pkg::A_MODE, {29'd0, mode});
    wr(dtg_pkg::A_POL, {29'd0, pol});
    wr(dtg_pkg::A_BORDER, {8'd0, BORDER});
    wr(dtg_pkg::A_UFLOW, {8'd0, UFLOW});
    @(negedge clk_i); #1;
    chk_off(pol, "R10 idle");
    wr(dtg_pkg::A_ENABLE, 1);
    for (int n = 0; n < ncyc; n++) begin
      int h, v;
      bit hs, vs, disp, act, dv;
      logic [23:0] px;
      @(negedge clk_i);
      pix_i = 24'h100000 + 24'(k);
      pix_valid_i = (k % 7) != 3;
      #1;
      h = k % HP; v = k % VP;
      hs = h < HPW; vs = v < VPW;
      disp = (h >= DH_LO && h <= DH_HI) && (v >= dvs && v <= dve);
      act = disp && (!mode[0] || (h >= AH_LO && h <= AH_HI)) && (!mode[1] || (v >= avs && v <= ave));
      dv = mode[2] && (h >= XH_LO && h <= XH_HI) && (v >= dvs && v <= dve);
      px = act ? (pix_valid_i ? pix_i : UFLOW) : BORDER;
      chk("R1 R7", "hsync", hsync_o, hs ^ pol[0]);
      chk("R2 R7", "vsync", vsync_o, vs ^ pol[1]);
      chk("R3 R7", "de", de_o, disp ^ pol[2]);
      chk("R4", "ready", pix_ready_o, act);
      chk("R4 R5", "pixel", pixel_o, px);
      chk("R6", "data_valid", data_valid_o, dv);
      chk("R8", "line", line_cnt_o, v / HP);
      chk("R8 R9", "frame", frame_cnt_o, k / VP);
      if (n == clr_at) begin
        cfg_we_i = 1; cfg_addr_i = dtg_pkg::A_CNT_CTL; cfg_wdata_i = 32'h8000_0000;
      end
      @(posedge clk_i);
      #2 cfg_we_i = 0;
      k = (n == clr_at) ? 0 : k + 1;
    end
    wr(dtg_pkg::A_ENABLE, 0);
    @(negedge clk_i); #1;
    chk_off(pol, "R10 stop");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk_off(3'b000, "R10 reset");
    rst_ni = 1;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++)
        run(3'(m), 3'(p), 0, ((m + p) % 3 == 0) ? VP - 1 : -1, 2 * VP + 10);
    // vertical positions shifted by an hsync skew; clear mid-frame
    run(3'b111, 3'b101, 3, 25, 2 * VP + 10);
    run(3'b011, 3'b000, 7, -1, 3 * VP);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule